// File: doc/BRIEF.md
# SPI Register and Command Slave

This block is the serial front end of a contactless-reader transceiver. It is a mode-1 SPI slave. The clock idles low, the master drives data on the rising edge, and both sides sample on the falling edge. Chip select is active low, and bytes travel MSB first. The slave samples `sclk_i`, `cs_ni` and `mosi_i` with the system clock. It expects each SPI half period to last at least 8 system clocks.

The first byte after chip select falls is a control byte. It names either a register access or a direct command.
- **Register accesses** may be single or auto-incrementing. Address 0x1F is a byte FIFO port. Address 0x1C reports the FIFO state. Address 0x0C holds interrupt flags that clear when read. Addresses 0x1D and 0x1E hold the transmit length.
- **Direct commands** can restore register defaults, empty the FIFO, or raise a transmit request toward the modem.

After a direct command or a single access, the next byte in the same frame is decoded as a new control byte. This lets one frame chain several operations.

Received data enters through `rx_push_i`. The modem drains transmit payload through `mdm_pop_i` and `mdm_data_o`.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, register 0x00 reads 0x01, register 0x01 reads 0x02, and every other plain register reads 0x00. At the same time `miso_o`, `irq_o` and `tx_start_o` are low and `tx_bytes_o` is 0.
- R2: The control byte is decoded as follows. Bit 7 = 1 marks a direct command, and its code is bits 4:0; bits 6:5 of a command byte are ignored. Bit 7 = 0 marks a register access: bit 6 = 1 means read, bit 5 = 1 means continuous, and bits 4:0 give the address.
- R3: A single write stores the next byte at the address. A single read returns the register on the next byte. After either one, the following byte in the frame is decoded as a control byte.
- R4: In a continuous access, the address advances by one after each data byte for as long as chip select stays low. For example, 0x60 followed by six reads returns registers 0x00 to 0x05.
- R5: In a continuous write, the address stops advancing at 0x1F. Every byte that lands at 0x1F is pushed into the FIFO.
- R6: Reading 0x1F returns the FIFO head and pops it once that byte has been clocked out, so a continuous read returns successive bytes. An empty FIFO reads 0x00. `rx_push_i` pushes `rx_data_i`. `mdm_data_o` shows the head (0x00 when empty), and `mdm_pop_i` removes it.
- R7: The FIFO holds 12 bytes. Register 0x1C reads the byte count in bits 4:0 and an overflow flag in bit 7. The flag is set, and the byte dropped, when a push arrives while the FIFO is full.
- R8: Each bit of `irq_set_i` sets the same bit of register 0x0C, and `irq_o` is high while any bit is set. Register 0x0C clears once it has been clocked out in a read. Writes to 0x0C are ignored.
- R9: `tx_bytes_o` is {reg 0x1D, reg 0x1E bits 7:4}. `tx_part_o` is reg 0x1E bit 0, and `tx_bits_o` is reg 0x1E bits 3:1.
- R10: Command 0x11 gives a one-cycle `tx_start_o` pulse with `tx_crc_o` = 1. Command 0x10 gives the same pulse with `tx_crc_o` = 0.
- R11: Command 0x0F empties the FIFO and clears the overflow flag.
- R12: Command 0x03 restores all registers to their reset values and clears register 0x0C. It leaves the FIFO contents unchanged.
- R13: Commands, register accesses and payload bytes can be chained in one frame. For example, 0x8F 0x91 0x3D 0x00 0x30 0x26 0x01 0x00 does the following:
  - empties the FIFO;
  - starts a transmit with CRC;
  - sets a length of 3 bytes;
  - queues three payload bytes.
- R14: Raising chip select in the middle of a byte discards the partial byte. The next frame starts with a control byte, and `miso_o` is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| rx_push_i | input | 1 | Push a received byte into the FIFO |
| rx_data_i | input | 8 | Received byte |
| mdm_pop_i | input | 1 | Modem removes the FIFO head |
| mdm_data_o | output | 8 | FIFO head, 0 when empty |
| irq_set_i | input | 8 | Interrupt flag set strobes |
| irq_o | output | 1 | Any interrupt flag set |
| tx_start_o | output | 1 | One-cycle transmit request |
| tx_crc_o | output | 1 | Transmit request asks for CRC |
| tx_bytes_o | output | 12 | Whole-byte transmit count |
| tx_part_o | output | 1 | Partial final byte present |
| tx_bits_o | output | 3 | Bit count of the partial byte |

## Verification
A decoder left in the wrong state shows up on the next byte of the same frame. A read then returns data from the wrong address, or a write lands in a register that a later read exposes. A lost or extra FIFO pop shifts every following byte of a continuous read from 0x1F. It also moves the count in 0x1C by one at the next status read. Interrupt and transmit-request errors show at `irq_o` and `tx_start_o` within a couple of system clocks of their cause.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] ADDR_CHIP     = 5'h00;
  localparam logic [AW-1:0] ADDR_ISO      = 5'h01;
  localparam logic [AW-1:0] ADDR_IRQ      = 5'h0C;
  localparam logic [AW-1:0] ADDR_FSTAT    = 5'h1C;
  localparam logic [AW-1:0] ADDR_TXLEN_HI = 5'h1D;
  localparam logic [AW-1:0] ADDR_TXLEN_LO = 5'h1E;
  localparam logic [AW-1:0] ADDR_FIFO     = 5'h1F;

  localparam logic [AW-1:0] CMD_SOFT_INIT = 5'h03;
  localparam logic [AW-1:0] CMD_FLUSH     = 5'h0F;
  localparam logic [AW-1:0] CMD_TX_RAW    = 5'h10;
  localparam logic [AW-1:0] CMD_TX_CRC    = 5'h11;

  localparam logic [DW-1:0] RST_CHIP = 8'h01;
  localparam logic [DW-1:0] RST_ISO  = 8'h02;

  typedef enum logic {DEC_CTRL, DEC_DATA} dec_st_e;

  function automatic logic [DW-1:0] reg_default(input logic [AW-1:0] a);
    case (a)
      ADDR_CHIP: return RST_CHIP;
      ADDR_ISO:  return RST_ISO;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_link.sv
module spi_cmd_link
  import spi_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          frame_o,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          miso_o
);
  localparam int BW = $clog2(DW);

  logic [2:0]    sclk_q;
  logic [1:0]    cs_q, mosi_q;
  logic          rise, fall;
  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] sh_in;
  logic [DW-1:0] tx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      cs_q   <= {cs_q[0], cs_ni};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  assign rise    = sclk_q[1] & ~sclk_q[2];
  assign fall    = ~sclk_q[1] & sclk_q[2];
  assign frame_o = ~cs_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      sh_in      <= '0;
      tx_sh      <= '0;
      miso_o     <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!frame_o) begin
        // partial byte is dropped here
        bit_cnt <= '0;
        tx_sh   <= '0;
        miso_o  <= 1'b0;
      end else begin
        if (fall) begin
          sh_in   <= {sh_in[DW-3:0], mosi_q[1]};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BW'(DW-1)) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {sh_in, mosi_q[1]};
          end
        end
        if (rise) miso_o <= tx_sh[DW-1];
        if (load_i)    tx_sh <= load_data_i;
        else if (rise) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_o == CW'(DEPTH));
  assign empty   = (cnt_o == '0);
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty;
  assign head_o  = empty ? '0 : mem[rptr];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wptr] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (flush_i) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (push_i && full) ovf_o <= 1'b1;
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      cnt_o <= cnt_o + 1'b1;
      else if (do_pop && !do_push) cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] irq_set_i,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic [DW-1:0] len_hi_o,
  output logic [DW-1:0] len_lo_o
);
  localparam int NREG = 2 ** AW;

  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reg_default(AW'(i));
    end else if (soft_rst_i) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reg_default(AW'(i));
    end else if (we_i && waddr_i != ADDR_IRQ) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // a set arriving with the clear wins, so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= '0;
    else if (soft_rst_i) irq_q <= '0;
    else                 irq_q <= (irq_q & ~{DW{irq_clr_i}}) | irq_set_i;
  end

  assign rdata_o  = (raddr_i == ADDR_IRQ) ? irq_q : mem[raddr_i];
  assign irq_o    = |irq_q;
  assign len_hi_o = mem[ADDR_TXLEN_HI];
  assign len_lo_o = mem[ADDR_TXLEN_LO];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          mdm_pop_i,
  output logic [DW-1:0] mdm_data_o,
  input  logic [DW-1:0] irq_set_i,
  output logic          irq_o,
  output logic          tx_start_o,
  output logic          tx_crc_o,
  output logic [DW+3:0] tx_bytes_o,
  output logic          tx_part_o,
  output logic [2:0]    tx_bits_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic          frame, byte_vld, load_pend;
  logic [DW-1:0] byte_q, rd_data, reg_rdata, fifo_head, len_hi, len_lo;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_ovf;
  dec_st_e       st;
  logic [AW-1:0] addr;
  logic          rd, cont;

  logic cmd_fire, wr_fire, rd_done, soft_rst, flush, spi_push, spi_pop;

  spi_cmd_link i_link (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .load_i(load_pend), .load_data_i(rd_data),
    .frame_o(frame), .byte_vld_o(byte_vld), .byte_o(byte_q), .miso_o
  );

  assign cmd_fire = byte_vld & (st == DEC_CTRL) & byte_q[7];
  assign wr_fire  = byte_vld & (st == DEC_DATA) & ~rd;
  assign rd_done  = byte_vld & (st == DEC_DATA) & rd;
  assign soft_rst = cmd_fire & (byte_q[AW-1:0] == CMD_SOFT_INIT);
  assign flush    = cmd_fire & (byte_q[AW-1:0] == CMD_FLUSH);
  assign spi_push = wr_fire & (addr == ADDR_FIFO);
  assign spi_pop  = rd_done & (addr == ADDR_FIFO);

  spi_cmd_regs i_regs (
    .clk_i, .rst_ni,
    .soft_rst_i(soft_rst),
    .we_i(wr_fire && addr != ADDR_FIFO && addr != ADDR_FSTAT),
    .waddr_i(addr), .wdata_i(byte_q),
    .raddr_i(addr), .rdata_o(reg_rdata),
    .irq_set_i, .irq_clr_i(rd_done && addr == ADDR_IRQ), .irq_o,
    .len_hi_o(len_hi), .len_lo_o(len_lo)
  );

  spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(spi_push | rx_push_i),
    .pdata_i(spi_push ? byte_q : rx_data_i),
    .pop_i(spi_pop | mdm_pop_i),
    .flush_i(flush),
    .head_o(fifo_head), .cnt_o(fifo_cnt), .ovf_o(fifo_ovf)
  );

  always_comb begin
    case (addr)
      ADDR_FIFO:  rd_data = fifo_head;
      ADDR_FSTAT: rd_data = {fifo_ovf, 2'b00, 5'(fifo_cnt)};
      default:    rd_data = reg_rdata;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= DEC_CTRL; addr <= '0; rd <= 1'b0; cont <= 1'b0; load_pend <= 1'b0;
    end else if (!frame) begin
      st <= DEC_CTRL; load_pend <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      if (byte_vld) begin
        if (st == DEC_CTRL) begin
          if (!byte_q[7]) begin
            addr      <= byte_q[AW-1:0];
            rd        <= byte_q[6];
            cont      <= byte_q[5];
            st        <= DEC_DATA;
            load_pend <= byte_q[6];
          end
        end else if (cont) begin
          if (addr != ADDR_FIFO) addr <= addr + 1'b1;
          load_pend <= rd;
        end else begin
          st <= DEC_CTRL;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_start_o <= 1'b0; tx_crc_o <= 1'b0;
    end else begin
      tx_start_o <= cmd_fire & (byte_q[AW-1:0] == CMD_TX_RAW || byte_q[AW-1:0] == CMD_TX_CRC);
      if (cmd_fire && (byte_q[AW-1:0] == CMD_TX_RAW || byte_q[AW-1:0] == CMD_TX_CRC))
        tx_crc_o <= byte_q[0];
    end
  end

  assign mdm_data_o = fifo_head;
  assign tx_bytes_o = {len_hi, len_lo[7:4]};
  assign tx_part_o  = len_lo[0];
  assign tx_bits_o  = len_lo[3:1];
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int DEPTH = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          miso_o,
  input logic          tx_start_o,
  input logic          irq_o,
  input logic [7:0]    irq_set_i,
  input logic [CW-1:0] fifo_cnt_i
);
  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(irq_set_i) != 8'h00));

  p_fifo_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH));

  p_fifo_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i != $past(fifo_cnt_i)) |->
      (fifo_cnt_i == '0 ||
       {1'b0, fifo_cnt_i} == {1'b0, $past(fifo_cnt_i)} + 1'b1 ||
       {1'b0, fifo_cnt_i} + 1'b1 == {1'b0, $past(fifo_cnt_i)}));

  p_miso_idle_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni, 1) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4)) |-> !miso_o);
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .miso_o(miso_o),
  .tx_start_o(tx_start_o), .irq_o(irq_o), .irq_set_i(irq_set_i),
  .fifo_cnt_i(fifo_cnt)
);

// File: tb/test_spi_cmd_slave.sv
`timescale 1ns/1ps
module test_spi_cmd_slave;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, rx_push = 1'b0, mdm_pop = 1'b0, irq, tx_start, tx_crc, tx_part;
  logic [7:0] rx_data = 8'h00, mdm_data, irq_set = 8'h00;
  logic [11:0] tx_bytes;
  logic [2:0] tx_bits;

  int nchk = 0, nerr = 0, st_cnt = 0;
  logic st_crc = 1'b0;
  logic [7:0] exp_q[$], act_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .mdm_pop_i(mdm_pop), .mdm_data_o(mdm_data), .irq_set_i(irq_set),
    .irq_o(irq), .tx_start_o(tx_start), .tx_crc_o(tx_crc),
    .tx_bytes_o(tx_bytes), .tx_part_o(tx_part), .tx_bits_o(tx_bits)
  );

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string r;
      a = act_q.pop_front(); e = exp_q.pop_front(); r = req_q.pop_front();
      nchk++;
      if (a !== e) begin
        nerr++;
        $display("FAIL %s: read got %02h expected %02h", r, a, e);
      end
    end
  end

  always @(negedge clk) if (tx_start) begin st_cnt++; st_crc = tx_crc; end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string r);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] d, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b1; mosi = d[7-i];
      wait_clk(H);
      r = {r[6:0], miso};
      sclk = 1'b0;
      wait_clk(H);
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; wait_clk(4); endtask
  task automatic cs_hi(); wait_clk(4); cs_n = 1'b1; wait_clk(8); endtask

  task automatic wb(input logic [7:0] d);
    logic [7:0] r;
    spi_bits(d, 8, r);
  endtask

  task automatic rb(input logic [7:0] e, input string req);
    logic [7:0] r;
    exp_q.push_back(e); req_q.push_back(req);
    spi_bits(8'h00, 8, r);
    act_q.push_back(r);
  endtask

  task automatic rx(input logic [7:0] d);
    rx_push = 1'b1; rx_data = d; wait_clk(1); rx_push = 1'b0; wait_clk(1);
  endtask

  initial begin
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    // R1 reset state
    chk(miso, 0, "R1 miso"); chk(irq, 0, "R1 irq"); chk(tx_start, 0, "R1 tx_start");
    chk(tx_bytes, 0, "R1 tx_bytes");
    // R4 continuous read of defaults
    cs_lo(); wb(8'h60);
    rb(8'h01, "R1 R4 reg00"); rb(8'h02, "R1 R4 reg01");
    rb(8'h00, "R4 reg02"); rb(8'h00, "R4 reg03"); rb(8'h00, "R4 reg04"); rb(8'h00, "R4 reg05");
    cs_hi();
    // R3 single write/read and chaining
    cs_lo(); wb(8'h05); wb(8'hA5); cs_hi();
    cs_lo(); wb(8'h45); rb(8'hA5, "R3 single read"); cs_hi();
    cs_lo(); wb(8'h05); wb(8'h3C); wb(8'h45); rb(8'h3C, "R3 chained"); cs_hi();
    // R4 continuous write and read back
    cs_lo(); wb(8'h22); wb(8'h11); wb(8'h22); wb(8'h33); cs_hi();
    cs_lo(); wb(8'h62); rb(8'h11, "R4 a"); rb(8'h22, "R4 b"); rb(8'h33, "R4 c"); cs_hi();
    // R13 R10 R5 chained frame
    cs_lo(); wb(8'h8F); wb(8'h91); wb(8'h3D); wb(8'h00); wb(8'h30);
    wb(8'h26); wb(8'h01); wb(8'h00); cs_hi();
    chk(st_cnt, 1, "R10 R13 start count"); chk(st_crc, 1, "R10 crc flag");
    chk(tx_bytes, 3, "R9 R13 tx_bytes"); chk(tx_part, 0, "R9 part");
    cs_lo(); wb(8'h5C); rb(8'h03, "R5 R7 fifo count"); cs_hi();
    // R6 modem pop and FIFO reads
    chk(mdm_data, 8'h26, "R6 head");
    mdm_pop = 1'b1; wait_clk(1); mdm_pop = 1'b0; wait_clk(1);
    chk(mdm_data, 8'h01, "R6 after pop");
    cs_lo(); wb(8'h7F); rb(8'h01, "R6 fifo0"); rb(8'h00, "R6 fifo1"); rb(8'h00, "R6 empty"); cs_hi();
    cs_lo(); wb(8'h5C); rb(8'h00, "R6 drained"); cs_hi();
    // R10 raw start, R9 partial byte
    cs_lo(); wb(8'h90); wb(8'h3D); wb(8'h00); wb(8'h0F); cs_hi();
    chk(st_cnt, 2, "R10 raw count"); chk(st_crc, 0, "R10 no crc");
    chk(tx_bytes, 0, "R9 bytes"); chk(tx_part, 1, "R9 part"); chk(tx_bits, 7, "R9 bits");
    // R7 overflow
    for (int i = 0; i < 13; i++) rx(8'(8'h40 + i));
    cs_lo(); wb(8'h5C); rb(8'h8C, "R7 full+ovf"); cs_hi();
    cs_lo(); wb(8'h7F);
    for (int i = 0; i < 12; i++) rb(8'(8'h40 + i), "R7 order");
    cs_hi();
    cs_lo(); wb(8'h5C); rb(8'h80, "R7 ovf sticky"); cs_hi();
    // R11 flush
    cs_lo(); wb(8'h8F); cs_hi();
    cs_lo(); wb(8'h5C); rb(8'h00, "R11 ovf cleared"); cs_hi();
    // R2 command ignores bits 6:5
    rx(8'hAA); rx(8'hBB);
    cs_lo(); wb(8'hEF); wb(8'h5C); rb(8'h00, "R2 masked flush"); cs_hi();
    // R8 interrupt flags
    irq_set = 8'h24; wait_clk(1); irq_set = 8'h00; wait_clk(2);
    chk(irq, 1, "R8 irq set");
    cs_lo(); wb(8'h0C); wb(8'hFF); cs_hi();
    cs_lo(); wb(8'h6C); rb(8'h24, "R8 status"); rb(8'h00, "R8 dummy"); cs_hi();
    chk(irq, 0, "R8 cleared");
    cs_lo(); wb(8'h4C); rb(8'h00, "R8 reread"); cs_hi();
    // R12 soft init
    cs_lo(); wb(8'h00); wb(8'h55); cs_hi();
    rx(8'h12); rx(8'h34);
    irq_set = 8'h01; wait_clk(1); irq_set = 8'h00; wait_clk(2);
    cs_lo(); wb(8'h83); cs_hi();
    cs_lo(); wb(8'h60); rb(8'h01, "R12 reg00"); rb(8'h02, "R12 reg01"); cs_hi();
    chk(tx_part, 0, "R12 len lo"); chk(irq, 0, "R12 irq");
    cs_lo(); wb(8'h5C); rb(8'h02, "R12 fifo kept"); cs_hi();
    // R14 aborted bytes
    begin
      logic [7:0] r;
      cs_lo(); spi_bits(8'h05, 4, r); cs_hi();
      chk(miso, 0, "R14 idle miso");
      cs_lo(); wb(8'h05); wb(8'h99); wb(8'h45); rb(8'h99, "R14 realigned"); cs_hi();
      cs_lo(); wb(8'h05); spi_bits(8'hEE, 4, r); cs_hi();
      cs_lo(); wb(8'h45); rb(8'h99, "R14 partial dropped"); cs_hi();
    end
    wait_clk(5);
    chk(exp_q.size(), 0, "scoreboard drained");
    summary();
    $finish;
  end
endmodule